// File: doc/BRIEF.md
# Prioritized Interrupt Request Recognizer

This block sits between a processor core and seven interrupt request lines, numbered 1 (lowest urgency) to 7 (highest). Each line is active-low and is formed by several sources pulling it down together, so any one source that asserts makes the whole line assert. The block brings each line into the clock domain and accepts it only once it has been seen asserted on two samples in a row. It then picks the most urgent qualified line that the current 3-bit priority mask does not block. Level 7 cannot be masked, and it is treated as a transition-qualified event rather than as a level.

The chosen level is shown to the core only after it reaches an instruction boundary or finishes a higher-priority exception; until then the request waits. The pending level is never stored. If a more urgent line qualifies, it takes over the output. If the pending line lets go, the request is gone. When the core takes the presented interrupt, the mask is loaded with the level being serviced. The core can also write the mask directly, for example when it returns from a handler.

The control is a three-state machine:
- **ST_IDLE**: no unmasked request exists.
- **ST_HELD**: a request exists and is waiting for a boundary or exception-done strobe.
- **ST_PRESENT**: the request is driven to the core.

The transitions are:
- **idle_to_held**: a request appears with no strobe in the same cycle.
- **idle_to_present**: a request appears together with a strobe.
- **held_to_present**: a strobe arrives while a request is waiting.
- **held_to_idle**: the waiting request vanishes.
- **present_to_idle**: the core takes the request, or the request vanishes.

Top module: `irq_recognizer`

## Requirements
- R1: A request line seen asserted on only one sample is never recognized, even after a later boundary strobe.
- R2: A line held asserted (low) for two or more samples becomes a request at its level, with `pend_level_o` carrying the level number 1 to 7 in binary.
- R3: For levels 1 to 6, a request whose level is less than or equal to `mask_o` is ignored completely. A mask of 0 blocks none of them.
- R4: The presented level is always the highest unmasked qualified level and is not latched. A more urgent line replaces it at once. A line that releases drops out, and the next lower request or nothing is shown.
- R5: `pend_valid_o` goes high only in the cycle after `boundary_i` or `exc_done_i` was high. Before that, a qualified request gives `pend_valid_o` = 0.
- R6: A `take_i` pulse while `pend_valid_o` is high loads `mask_o` with the presented level on the next clock and drops `pend_valid_o`.
- R7: Level 7 ignores the mask. Each new assertion of line 7 produces exactly one event, and once that event is taken, a line held low gives no further request.
- R8: A mask write from 7 to any lower value while line 7 is still held produces a fresh level-7 event. The same write with line 7 released produces none.
- R9: Each level line is the wired combination of `SRCS` active-low sources. Source `s` of level `L` sits at bit `(L-1)*SRCS + s` of `src_req_n`, and any single asserted source asserts the line.
- R10: Reset gives `mask_o` = 7 and `pend_valid_o` = 0. A `mask_wr_i` pulse with no take in the same cycle loads `mask_wdata_i` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req_n | input | 7*SRCS | Active-low request sources, SRCS per level |
| boundary_i | input | 1 | Instruction-boundary strobe from the core |
| exc_done_i | input | 1 | Higher-priority exception finished strobe |
| take_i | input | 1 | Core accepts the presented interrupt |
| mask_wr_i | input | 1 | Direct mask write enable |
| mask_wdata_i | input | 3 | Mask value to write |
| mask_o | output | 3 | Current priority mask |
| pend_valid_o | output | 1 | Interrupt presented to the core |
| pend_level_o | output | 3 | Presented level, 0 when none |

## Verification
The bench drives single-sample glitches, which a design without the two-sample qualifier would turn into interrupts. It raises a higher line over a pending lower one, then drops lines, to catch a design that latches the first level it saw. Level 7 is held across a take to expose a design that re-fires it as a plain level and overflows the handler. Line 7 is also held through a mask write that drops the mask from 7, where a design without re-arming would lose the event, and through the same write with the line released, where a careless design would invent one.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
    localparam int LVLW = 3;
    localparam int NLEV = 7;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HELD,
        ST_PRESENT
    } rec_state_e;
endpackage

// File: rtl/irq_line_qual.sv
module irq_line_qual #(
    parameter int NLEV        = 7,
    parameter int SRCS        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLEV*SRCS-1:0] src_req_n,
    output logic [NLEV-1:0]      lvl_valid
);
    for (genvar g = 0; g < NLEV; g++) begin : g_lvl
        logic                   line_act;
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;

        // wired combination: any low source pulls the line low
        assign line_act = ~(&src_req_n[g*SRCS +: SRCS]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= '0;
                prev_q <= 1'b0;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], line_act};
                prev_q <= sync_q[SYNC_STAGES-1];
            end
        end

        assign lvl_valid[g] = sync_q[SYNC_STAGES-1] & prev_q;
    end
endmodule

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect
    import irq_rec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            top_valid,
    input  logic [LVLW-1:0] mask_q,
    input  logic            mask_wr,
    input  logic [LVLW-1:0] mask_wdata,
    input  logic            take_ok,
    input  logic [LVLW-1:0] take_lvl,
    output logic            nmi_flag
);
    localparam logic [LVLW-1:0] TOP = LVLW'(NLEV);

    logic top_d;
    logic set_edge;
    logic set_redrop;
    logic clr;

    assign set_edge   = top_valid & ~top_d;
    assign set_redrop = top_valid & mask_wr & ~take_ok & (mask_q == TOP) & (mask_wdata != TOP);
    assign clr        = take_ok & (take_lvl == TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_d    <= 1'b0;
            nmi_flag <= 1'b0;
        end else begin
            top_d    <= top_valid;
            nmi_flag <= top_valid & (set_edge | set_redrop | (nmi_flag & ~clr));
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_rec_pkg::*;
(
    input  logic [NLEV-1:0] lvl_valid,
    input  logic            nmi_flag,
    input  logic [LVLW-1:0] mask_q,
    output logic            cand,
    output logic [LVLW-1:0] best_lvl
);
    always_comb begin
        best_lvl = '0;
        for (int l = 1; l < NLEV; l++) begin
            if (lvl_valid[l-1] && (LVLW'(l) > mask_q)) begin
                best_lvl = LVLW'(l);
            end
        end
        if (nmi_flag) begin
            best_lvl = LVLW'(NLEV);
        end
        cand = (best_lvl != '0);
    end
endmodule

// File: rtl/irq_recognizer.sv
module irq_recognizer
    import irq_rec_pkg::*;
#(
    parameter int SRCS        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLEV*SRCS-1:0] src_req_n,
    input  logic                 boundary_i,
    input  logic                 exc_done_i,
    input  logic                 take_i,
    input  logic                 mask_wr_i,
    input  logic [LVLW-1:0]      mask_wdata_i,
    output logic [LVLW-1:0]      mask_o,
    output logic                 pend_valid_o,
    output logic [LVLW-1:0]      pend_level_o
);
    logic [NLEV-1:0] lvl_valid;
    logic            nmi_flag;
    logic            cand;
    logic [LVLW-1:0] best_lvl;
    logic [LVLW-1:0] mask_q;
    logic            strobe;
    logic            take_ok;
    rec_state_e      state_q, state_d;

    irq_line_qual #(
        .NLEV        (NLEV),
        .SRCS        (SRCS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_req_n (src_req_n),
        .lvl_valid (lvl_valid)
    );

    irq_nmi_detect u_nmi (
        .clk        (clk),
        .rst_n      (rst_n),
        .top_valid  (lvl_valid[NLEV-1]),
        .mask_q     (mask_q),
        .mask_wr    (mask_wr_i),
        .mask_wdata (mask_wdata_i),
        .take_ok    (take_ok),
        .take_lvl   (best_lvl),
        .nmi_flag   (nmi_flag)
    );

    irq_prio_sel u_sel (
        .lvl_valid (lvl_valid),
        .nmi_flag  (nmi_flag),
        .mask_q    (mask_q),
        .cand      (cand),
        .best_lvl  (best_lvl)
    );

    assign strobe  = boundary_i | exc_done_i;
    assign take_ok = take_i & pend_valid_o;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cand) state_d = strobe ? ST_PRESENT : ST_HELD;
            end
            ST_HELD: begin
                if (!cand)       state_d = ST_IDLE;
                else if (strobe) state_d = ST_PRESENT;
            end
            ST_PRESENT: begin
                if (!cand || take_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend_valid_o = (state_q == ST_PRESENT) && cand;
        pend_level_o = pend_valid_o ? best_lvl : '0;
    end

    // mask register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= LVLW'(NLEV);
        end else if (take_ok) begin
            mask_q <= best_lvl;
        end else if (mask_wr_i) begin
            mask_q <= mask_wdata_i;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_recognizer_sva.sv
module irq_recognizer_sva
    import irq_rec_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            boundary_i,
    input logic            exc_done_i,
    input logic            take_i,
    input logic [LVLW-1:0] mask_o,
    input logic            pend_valid_o,
    input logic [LVLW-1:0] pend_level_o
);
    localparam logic [LVLW-1:0] TOP = LVLW'(NLEV);

    assert_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid_o && pend_level_o != TOP) |-> (pend_level_o > mask_o));

    assert_strobe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_valid_o) |-> $past(boundary_i || exc_done_i));

    assert_take_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && pend_valid_o) |=> (mask_o == $past(pend_level_o)));

    assert_take_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && pend_valid_o) |=> !pend_valid_o);

    assert_level_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid_o |-> (pend_level_o != '0));

    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_valid_o |-> (pend_level_o == '0));
endmodule

bind irq_recognizer irq_recognizer_sva u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .boundary_i   (boundary_i),
    .exc_done_i   (exc_done_i),
    .take_i       (take_i),
    .mask_o       (mask_o),
    .pend_valid_o (pend_valid_o),
    .pend_level_o (pend_level_o)
);

// File: tb/tb_irq_recognizer.sv
module tb_irq_recognizer;
    localparam int CLK_PERIOD = 10;
    localparam int SRCS = 2;
    localparam int NL = 7;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL*SRCS-1:0] src_req_n = '1;
    logic            boundary_i = 1'b0;
    logic            exc_done_i = 1'b0;
    logic            take_i = 1'b0;
    logic            mask_wr_i = 1'b0;
    logic [2:0]      mask_wdata_i = 3'd0;
    logic [2:0]      mask_o;
    logic            pend_valid_o;
    logic [2:0]      pend_level_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_recognizer #(.SRCS(SRCS), .SYNC_STAGES(2)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_req_n    (src_req_n),
        .boundary_i   (boundary_i),
        .exc_done_i   (exc_done_i),
        .take_i       (take_i),
        .mask_wr_i    (mask_wr_i),
        .mask_wdata_i (mask_wdata_i),
        .mask_o       (mask_o),
        .pend_valid_o (pend_valid_o),
        .pend_level_o (pend_level_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_pend(input string req, input int v, input int lvl);
        chk({req, " valid"}, int'(pend_valid_o), v);
        chk({req, " level"}, int'(pend_level_o), lvl);
    endtask

    task automatic set_src(input int lvl, input int s, input bit on);
        src_req_n[(lvl-1)*SRCS + s] = ~on;
    endtask

    task automatic wr_mask(input int m);
        mask_wr_i = 1'b1;
        mask_wdata_i = 3'(m);
        step(1);
        mask_wr_i = 1'b0;
    endtask

    task automatic pulse_boundary();
        boundary_i = 1'b1;
        step(1);
        boundary_i = 1'b0;
    endtask

    task automatic pulse_take();
        take_i = 1'b1;
        step(1);
        take_i = 1'b0;
    endtask

    task automatic t_reset();
        step(2);
        chk("R10 reset mask", int'(mask_o), 7);
        chk_pend("R10 reset pend", 0, 0);
        wr_mask(0);
        chk("R10 mask write", int'(mask_o), 0);
    endtask

    task automatic t_glitch();
        set_src(3, 0, 1);
        step(1);
        set_src(3, 0, 0);
        step(6);
        pulse_boundary();
        chk_pend("R1 glitch ignored", 0, 0);
    endtask

    task automatic t_basic();
        set_src(3, 0, 1);
        step(6);
        chk_pend("R5 waits for strobe", 0, 0);
        pulse_boundary();
        chk_pend("R2 level 3 pending", 1, 3);
        pulse_take();
        chk("R6 mask loaded", int'(mask_o), 3);
        chk_pend("R6 dropped after take", 0, 0);
        set_src(3, 0, 0);
        wr_mask(0);
        step(5);
    endtask

    task automatic t_mask();
        wr_mask(4);
        set_src(4, 0, 1);
        step(6);
        pulse_boundary();
        chk_pend("R3 equal to mask blocked", 0, 0);
        set_src(5, 0, 1);
        step(6);
        pulse_boundary();
        chk_pend("R3 above mask passes", 1, 5);
        set_src(4, 0, 0);
        set_src(5, 0, 0);
        step(5);
        chk_pend("R4 released", 0, 0);
        wr_mask(0);
        set_src(1, 0, 1);
        step(6);
        pulse_boundary();
        chk_pend("R3 mask 0 passes level 1", 1, 1);
        set_src(1, 0, 0);
        step(5);
    endtask

    task automatic t_priority();
        set_src(2, 0, 1);
        step(6);
        pulse_boundary();
        chk_pend("R4 level 2", 1, 2);
        set_src(6, 0, 1);
        step(5);
        chk_pend("R4 higher replaces", 1, 6);
        set_src(6, 0, 0);
        step(5);
        chk_pend("R4 falls back", 1, 2);
        set_src(2, 0, 0);
        step(5);
        chk_pend("R4 vanishes", 0, 0);
        pulse_boundary();
        chk_pend("R4 nothing left", 0, 0);
    endtask

    task automatic t_exc_done();
        set_src(4, 1, 1);
        step(6);
        exc_done_i = 1'b1;
        step(1);
        exc_done_i = 1'b0;
        chk_pend("R5 exc_done strobe", 1, 4);
        pulse_take();
        chk("R6 mask 4", int'(mask_o), 4);
        set_src(4, 1, 0);
        wr_mask(0);
        step(5);
    endtask

    task automatic t_nmi();
        wr_mask(7);
        set_src(7, 0, 1);
        step(6);
        pulse_boundary();
        chk_pend("R7 level 7 past mask 7", 1, 7);
        pulse_take();
        chk("R6 mask 7", int'(mask_o), 7);
        step(6);
        pulse_boundary();
        chk_pend("R7 no refire while held", 0, 0);
        wr_mask(3);
        step(3);
        pulse_boundary();
        chk_pend("R8 redrop fires", 1, 7);
        pulse_take();
        set_src(7, 0, 0);
        step(5);
        wr_mask(2);
        step(3);
        pulse_boundary();
        chk_pend("R8 no event when released", 0, 0);
        wr_mask(7);
        set_src(7, 0, 1);
        step(6);
        pulse_boundary();
        chk_pend("R7 new assertion fires", 1, 7);
        pulse_take();
        set_src(7, 0, 0);
        wr_mask(0);
        step(5);
    endtask

    task automatic t_wired();
        set_src(5, 1, 1);
        step(6);
        pulse_boundary();
        chk_pend("R9 single source", 1, 5);
        set_src(5, 0, 1);
        step(2);
        set_src(5, 1, 0);
        step(5);
        chk_pend("R9 other source holds", 1, 5);
        set_src(5, 0, 0);
        step(5);
        chk_pend("R9 all released", 0, 0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_glitch();
        t_basic();
        t_mask();
        t_priority();
        t_exc_done();
        t_nmi();
        t_wired();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule